// File: doc/BRIEF.md
# Input Protection Switch Gate Controller

This block chooses how the gate of an external series input-protection transistor is driven. It drives the gate in one of three ways. A pull-up to the input rail holds the transistor off. A weak current-source pull-down turns it on slowly, which limits inrush current. A strong resistive pull-down holds it fully on once the boost output is in regulation. The analog drivers and comparators sit outside the block. Each comparator result arrives as a synchronous digital flag, and the block returns a registered one-hot code that selects exactly one driver.

The block is armed only while the enable input and the undervoltage-lockout-ok flag are both high. Once armed, it ramps the gate with the weak pull-down. It moves to the strong pull-down when the gate has crossed its low threshold and the boost output is inside its regulation window, both in the same cycle. If regulation is later lost, it drops back to the weak pull-down. A timed fault forces the gate off and keeps it off until the block is disarmed. A second output tells the power sequencer that the gate has crossed the start threshold, so the boost soft-start may begin.

Top module: `inrush_gate_ctrl`

## Requirements
- R1: During synchronous active-low reset and in the first cycle after it, `drive_mode` is 3'b001 (pull-up) and `boost_start_ok` is 0.
- R2: After any clock edge where `enable` or `uvlo_ok` is low, `drive_mode` is 3'b001. This holds in every state, the fault state included, and it takes priority over `timed_fault`.
- R3: From the pull-up state, after an edge where `enable` and `uvlo_ok` are both high and `timed_fault` is low, `drive_mode` is 3'b010 (weak pull-down).
- R4: From the weak state, `drive_mode` becomes 3'b100 (strong pull-down) after an edge where `gate_lo` and `boost_in_reg` are both high while the block is armed without fault. If either flag is low, it stays 3'b010.
- R5: From the strong state, after an armed, fault-free edge where `boost_in_reg` is low, `drive_mode` returns to 3'b010. While `boost_in_reg` stays high, it remains 3'b100, whatever `gate_lo` does.
- R6: After an edge where the block is armed and `timed_fault` is high, `drive_mode` is 3'b001, from any state.
- R7: The fault state is sticky. While the block stays armed, `drive_mode` stays 3'b001 even after `timed_fault` falls. Only a disarming edge returns the block to the plain off state, from which R3 applies again.
- R8: `boost_start_ok` is 1 after an edge exactly when the new drive is the weak or the strong pull-down and `gate_below_start` was high at that edge. Otherwise it is 0, so it is never 1 while `drive_mode` is 3'b001.
- R9: `drive_mode` always has exactly one bit set: bit 0 pull-up, bit 1 weak pull-down, bit 2 strong pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Chip enable request |
| uvlo_ok | input | 1 | Internal regulator above its rising lockout threshold |
| gate_lo | input | 1 | Gate voltage below the low (strong-drive) threshold |
| gate_below_start | input | 1 | Gate voltage below the soft-start threshold |
| boost_in_reg | input | 1 | Boost output inside its regulation window |
| timed_fault | input | 1 | Timed fault detected elsewhere |
| drive_mode | output | 3 | One-hot gate drive: [0] pull-up, [1] weak pull-down, [2] strong pull-down |
| boost_start_ok | output | 1 | Gate past the start threshold, boost may start |

## Verification
Two situations are provoked directly because they fall in the same cycle. In the first, a timed fault arrives on the same edge where the strong-drive entry conditions are met. In the second, a disarm coincides with a fault. The expected results are pull-up for the first (the fault beats the upgrade) and plain off for the second (the disarm beats the fault), so the next arming gives weak drive, not a held fault. A bench model computes the next state from the stated priorities. Random flag patterns with a high arming probability hit these overlaps repeatedly, and every cycle is compared against that model.

// File: rtl/inrush_gate_pkg.sv
// Package: shared state type and drive encodings for the inrush gate controller.
// Assumes: drive code bit positions are fixed because the analog driver decodes them.
package inrush_gate_pkg;

    localparam int DRV_W = 3;

    // Bit positions of the one-hot drive code (decoded by the analog driver).
    localparam int DRV_BIT_UP     = 0;
    localparam int DRV_BIT_WEAK   = 1;
    localparam int DRV_BIT_STRONG = 2;

    localparam logic [DRV_W-1:0] DRV_PULLUP = DRV_W'(1) << DRV_BIT_UP;
    localparam logic [DRV_W-1:0] DRV_WEAK   = DRV_W'(1) << DRV_BIT_WEAK;
    localparam logic [DRV_W-1:0] DRV_STRONG = DRV_W'(1) << DRV_BIT_STRONG;

    typedef enum logic [1:0] {
        GS_OFF    = 2'd0,
        GS_WEAK   = 2'd1,
        GS_STRONG = 2'd2,
        GS_FAULT  = 2'd3
    } gate_state_t;

endpackage

// File: rtl/ipg_qualify.sv
// Module: ipg_qualify
// Reduces the raw status flags to the two control terms used by the state
// machine: "armed" (enable and supply good) and "trip" (fault while armed).
// Assumes: all flags are already synchronous to clk.
module ipg_qualify (
    input  logic enable,
    input  logic uvlo_ok,
    input  logic timed_fault,
    output logic armed,
    output logic trip
);

    // Arming and fault qualification; disarm dominates fault.
    always_comb begin
        armed = enable & uvlo_ok;
        trip  = armed & timed_fault;
    end

endmodule

// File: rtl/ipg_fsm.sv
// Module: ipg_fsm
// Holds the gate drive state and computes its successor.
// Priority: disarm > fault > normal ramp/regulation transitions.
// Assumes: synchronous active-low reset; gate_lo and boost_in_reg are clean flags.
module ipg_fsm
    import inrush_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        armed,
    input  logic        trip,
    input  logic        gate_lo,
    input  logic        boost_in_reg,
    output gate_state_t state_q,
    output gate_state_t state_d
);

    // Next-state selection by priority.
    always_comb begin
        state_d = state_q;
        if (!armed) begin
            state_d = GS_OFF;
        end else if (trip) begin
            state_d = GS_FAULT;
        end else begin
            unique case (state_q)
                GS_OFF:    state_d = GS_WEAK;
                GS_WEAK:   state_d = (gate_lo && boost_in_reg) ? GS_STRONG : GS_WEAK;
                GS_STRONG: state_d = boost_in_reg ? GS_STRONG : GS_WEAK;
                GS_FAULT:  state_d = GS_FAULT;
                default:   state_d = GS_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_OFF;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/ipg_drive_out.sv
// Module: ipg_drive_out
// Registers the one-hot drive code and the boost start permission from the
// next state, so both outputs change on the same edge as the state.
// Assumes: synchronous active-low reset.
module ipg_drive_out
    import inrush_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  gate_state_t      state_d,
    input  logic             gate_below_start,
    output logic [DRV_W-1:0] drive_q,
    output logic             start_ok_q
);

    logic [DRV_W-1:0] drive_d;
    logic             conducting_d;

    // Decode next state into driver select.
    always_comb begin
        unique case (state_d)
            GS_WEAK:   drive_d = DRV_WEAK;
            GS_STRONG: drive_d = DRV_STRONG;
            default:   drive_d = DRV_PULLUP;
        endcase
        conducting_d = (state_d == GS_WEAK) || (state_d == GS_STRONG);
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q    <= DRV_PULLUP;
            start_ok_q <= 1'b0;
        end else begin
            drive_q    <= drive_d;
            start_ok_q <= conducting_d & gate_below_start;
        end
    end

endmodule

// File: rtl/inrush_gate_ctrl.sv
// Module: inrush_gate_ctrl (top)
// Selects pull-up, weak pull-down or strong pull-down for the gate of an
// external input-protection switch, and flags when boost soft-start may begin.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module inrush_gate_ctrl
    import inrush_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             uvlo_ok,
    input  logic             gate_lo,
    input  logic             gate_below_start,
    input  logic             boost_in_reg,
    input  logic             timed_fault,
    output logic [DRV_W-1:0] drive_mode,
    output logic             boost_start_ok
);

    logic        armed;
    logic        trip;
    gate_state_t state_q;
    gate_state_t state_d;

    ipg_qualify u_qual (
        .enable      (enable),
        .uvlo_ok     (uvlo_ok),
        .timed_fault (timed_fault),
        .armed       (armed),
        .trip        (trip)
    );

    ipg_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .armed        (armed),
        .trip         (trip),
        .gate_lo      (gate_lo),
        .boost_in_reg (boost_in_reg),
        .state_q      (state_q),
        .state_d      (state_d)
    );

    ipg_drive_out u_out (
        .clk              (clk),
        .rst_n            (rst_n),
        .state_d          (state_d),
        .gate_below_start (gate_below_start),
        .drive_q          (drive_mode),
        .start_ok_q       (boost_start_ok)
    );

endmodule

// File: rtl/inrush_gate_chk.sv
// Module: inrush_gate_chk
// Port-level temporal checks for inrush_gate_ctrl, attached by bind.
module inrush_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       uvlo_ok,
    input logic       gate_lo,
    input logic       gate_below_start,
    input logic       boost_in_reg,
    input logic       timed_fault,
    input logic [2:0] drive_mode,
    input logic       boost_start_ok
);

    // R2
    disarm_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || !uvlo_ok) |=> (drive_mode == 3'b001));

    // R6
    fault_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && uvlo_ok && timed_fault) |=> (drive_mode == 3'b001));

    // R4
    strong_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_mode[2]) |-> $past(gate_lo && boost_in_reg));

    // R5
    strong_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_mode[2] && enable && uvlo_ok && !timed_fault && !boost_in_reg)
        |=> (drive_mode == 3'b010));

    // R8
    start_not_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boost_start_ok |-> !drive_mode[0]);

    // R9
    onehot_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drive_mode) == 1);

endmodule

bind inrush_gate_ctrl inrush_gate_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .enable           (enable),
    .uvlo_ok          (uvlo_ok),
    .gate_lo          (gate_lo),
    .gate_below_start (gate_below_start),
    .boost_in_reg     (boost_in_reg),
    .timed_fault      (timed_fault),
    .drive_mode       (drive_mode),
    .boost_start_ok   (boost_start_ok)
);

// File: tb/sim_inrush_gate_ctrl.sv
module sim_inrush_gate_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, uvlo_ok = 1'b0, gate_lo = 1'b0;
    logic       gate_below_start = 1'b0, boost_in_reg = 1'b0, timed_fault = 1'b0;
    logic [2:0] drive_mode;
    logic       boost_start_ok;

    int n_chk = 0;
    int n_bad = 0;
    int mst   = 0;   // model state: 0 off, 1 weak, 2 strong, 3 fault
    logic mstart = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    inrush_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .uvlo_ok(uvlo_ok),
        .gate_lo(gate_lo), .gate_below_start(gate_below_start),
        .boost_in_reg(boost_in_reg), .timed_fault(timed_fault),
        .drive_mode(drive_mode), .boost_start_ok(boost_start_ok)
    );

    // Next state from the requirements (R2..R7).
    function automatic int nxt(int s, logic en, logic uv, logic lo, logic rg, logic ft);
        if (!(en && uv)) return 0;
        if (ft) return 3;
        case (s)
            0: return 1;
            1: return (lo && rg) ? 2 : 1;
            2: return rg ? 2 : 1;
            default: return 3;
        endcase
    endfunction

    function automatic logic [2:0] enc(int s);
        case (s)
            1: return 3'b010;
            2: return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

    task automatic chk(string req);
        n_chk++;
        if (drive_mode !== enc(mst) || boost_start_ok !== mstart) begin
            n_bad++;
            $display("FAIL %s: drive=%b start=%b expected drive=%b start=%b",
                     req, drive_mode, boost_start_ok, enc(mst), mstart);
        end
    endtask

    // Apply inputs at negedge, advance model, check at the next negedge.
    task automatic cyc(logic en, logic uv, logic lo, logic bs, logic rg, logic ft, string req);
        enable = en; uvlo_ok = uv; gate_lo = lo; gate_below_start = bs;
        boost_in_reg = rg; timed_fault = ft;
        mst    = nxt(mst, en, uv, lo, rg, ft);
        mstart = (mst == 1 || mst == 2) && bs;
        @(negedge clk);
        chk(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5A17));
        @(negedge clk);
        @(negedge clk);
        chk("R1 in reset");
        rst_n = 1'b1;
        // first cycle after reset, still disarmed
        cyc(0,0,0,0,0,0, "R1 after reset");
        // power up with enable high, lockout not yet released
        cyc(1,0,1,1,1,0, "R2 uvlo low holds off");
        cyc(1,0,1,1,1,0, "R2 uvlo low holds off");
        cyc(1,1,0,0,0,0, "R3 arm to weak");
        cyc(1,1,1,0,0,0, "R4 gate low only stays weak");
        cyc(1,1,0,1,1,0, "R4 in reg only stays weak, R8 start");
        cyc(1,1,1,1,1,0, "R4 both give strong");
        cyc(1,1,0,1,1,0, "R5 strong held, gate_lo ignored");
        cyc(1,1,1,0,0,0, "R5 reg lost to weak");
        cyc(1,1,1,1,1,0, "R4 re-enter strong");
        cyc(1,1,1,1,1,1, "R6 fault from strong");
        cyc(1,1,1,1,1,0, "R7 fault sticky");
        cyc(1,1,0,1,1,0, "R7 fault sticky");
        cyc(0,1,0,1,1,0, "R7 disarm clears");
        cyc(1,1,0,1,0,0, "R7 rearm weak R8");
        // same-cycle collisions
        cyc(1,1,1,0,1,1, "R6 fault beats strong entry");
        cyc(1,1,1,1,1,1, "R6 fault held");
        cyc(0,1,0,0,0,1, "R2 disarm beats fault");
        cyc(1,1,0,0,0,0, "R3 weak after disarm");
        cyc(1,0,0,1,0,1, "R2 uvlo beats fault");
        cyc(1,1,0,1,0,1, "R6 fault from off");
        for (int i = 0; i < 4000; i++) begin
            logic en, uv, lo, bs, rg, ft;
            en = ($urandom % 10) != 0;
            uv = ($urandom % 12) != 0;
            lo = $urandom % 2;
            bs = $urandom % 2;
            rg = ($urandom % 4) != 0;
            ft = ($urandom % 25) == 0;
            cyc(en, uv, lo, bs, rg, ft, "R9 random R8");
        end
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule